// File: doc/BRIEF.md
# DMA Request Splitter with Direct Completion Placement

This block accepts one large DMA transfer and breaks it into a stream of sub-requests that a PCIe-style link will accept. Each transfer names a link-side address, a local-side address, a byte length and a direction. Read sub-requests are sized by a programmable maximum read request size, and write sub-requests by a programmable maximum payload size. No sub-request is allowed to cross a 4 KB line of the link address space.

For reads, each sub-request takes a tag from a small pool. A per-tag table keeps the next local address for that tag and the number of dwords still owed to it. Completion data beats can arrive with their tags interleaved in any order. Each beat becomes a local memory write in the same cycle, at the address held for its tag, so no reorder storage is needed. A tag returns to the pool when its last dword arrives. A one-cycle done pulse closes each transfer, and after it the block accepts a new request.

Top module: `dma_split_place`

## Requirements
- R1: During and right after reset, req_ready is 1 and sub_valid, lw_valid and done are 0.
- R2: Each sub-request length equals the smallest of three values: the bytes still to issue, the bytes from sub_addr up to the next multiple of 4096, and the active size limit.
- R3: No sub-request crosses a 4 KB boundary: (sub_addr mod 4096) + sub_len is at most 4096.
- R4: The size limit is 128 << n bytes, where n is the 3-bit code on cfg_mrrs for reads and on cfg_mps for writes. Codes 5, 6 and 7 all mean 4096 bytes.
- R5: Sub-requests of one transfer start at the request's link and local addresses. Each one advances both addresses by its length, and the lengths add up to the request length. sub_is_read repeats the request direction.
- R6: A read sub-request carries the lowest-numbered free tag. While every tag is outstanding and no sub-request is already being offered, sub_valid stays 0.
- R7: Every completion beat (one dword) gives lw_valid in the same cycle, with lw_data equal to cpl_data. lw_addr is the local base of that tag's sub-request plus 4 times the beats already received for that tag. Tags may interleave in any order, and every dword of a read transfer is written exactly once.
- R8: A tag becomes free for reuse once its final dword has arrived.
- R9: done pulses for exactly one cycle. For a write, it comes in the cycle after the last sub-request is accepted. For a read, it comes in the cycle after the last completion dword. req_ready is 0 from the cycle after acceptance until done, and is 1 from the done cycle on.
- R10: Once offered, a sub-request keeps sub_valid, sub_addr, sub_len and sub_tag unchanged until sub_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_is_read | input | 1 | 1 = link-to-local read, 0 = local-to-link write |
| req_link | input | AW | Dword-aligned link-side start address |
| req_local | input | AW | Dword-aligned local-side start address |
| req_len | input | LW | Byte length, multiple of 4, 4 to 1 MiB - 4 |
| cfg_mps | input | 3 | Max payload code for writes |
| cfg_mrrs | input | 3 | Max read request code for reads |
| sub_valid | output | 1 | Sub-request offered |
| sub_ready | input | 1 | Sub-request taken by the link side |
| sub_is_read | output | 1 | Direction of the sub-request |
| sub_addr | output | AW | Link address of the sub-request |
| sub_local | output | AW | Matching local address |
| sub_len | output | 13 | Sub-request byte count (4..4096) |
| sub_tag | output | TW | Tag of a read sub-request (0 for writes) |
| cpl_valid | input | 1 | Completion dword present |
| cpl_tag | input | TW | Tag the dword belongs to |
| cpl_data | input | DW | Completion dword |
| lw_valid | output | 1 | Local write strobe |
| lw_addr | output | AW | Local write byte address |
| lw_data | output | DW | Local write data |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions rely on a well-behaved environment. Completions carry only tags that are outstanding, each tag gets exactly as many beats as it asked for, and the beats for one tag come in address order. The configuration codes hold steady while a transfer runs, and addresses and lengths are whole dwords. The bench keeps to these rules by choosing completion tags only from its own model of outstanding tags, in reverse or scrambled order across tags. It changes the codes only between transfers and uses dword-aligned values. It also holds sub_ready low at random, so that held offers and tag exhaustion both occur.

// File: rtl/dma_split_place.sv
`timescale 1ns/1ps
module dma_split_place #(
  parameter int AW   = 32,
  parameter int LW   = 20,
  parameter int DW   = 32,
  parameter int TAGS = 4,
  localparam int TW  = $clog2(TAGS),
  localparam int SW  = 13,
  localparam int CW  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_is_read,
  input  logic [AW-1:0] req_link,
  input  logic [AW-1:0] req_local,
  input  logic [LW-1:0] req_len,
  input  logic [2:0]    cfg_mps,
  input  logic [2:0]    cfg_mrrs,
  output logic          sub_valid,
  input  logic          sub_ready,
  output logic          sub_is_read,
  output logic [AW-1:0] sub_addr,
  output logic [AW-1:0] sub_local,
  output logic [SW-1:0] sub_len,
  output logic [TW-1:0] sub_tag,
  input  logic          cpl_valid,
  input  logic [TW-1:0] cpl_tag,
  input  logic [DW-1:0] cpl_data,
  output logic          lw_valid,
  output logic [AW-1:0] lw_addr,
  output logic [DW-1:0] lw_data,
  output logic          done
);

  logic          active, is_rd, hold;
  logic [AW-1:0] link_a, loc_a;
  logic [LW-1:0] rem, rx_left, cut;
  logic [TAGS-1:0] busy;
  logic [AW-1:0] t_addr [TAGS];
  logic [CW-1:0] t_cnt  [TAGS];
  logic [TW-1:0] tag_q, free_tag;
  logic          any_free, issue, cpl_ok;
  logic [2:0]    enc, enc_c;
  logic [SW-1:0] lim, to_bnd;

  always_comb begin
    free_tag = '0;
    any_free = 1'b0;
    for (int i = TAGS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_tag = TW'(i);
        any_free = 1'b1;
      end
    end
  end

  assign enc    = is_rd ? cfg_mrrs : cfg_mps;
  assign enc_c  = (enc > 3'd5) ? 3'd5 : enc;
  assign lim    = SW'(128) << enc_c;
  assign to_bnd = SW'(4096) - {1'b0, link_a[11:0]};

  always_comb begin
    cut = rem;
    if (LW'(to_bnd) < cut) cut = LW'(to_bnd);
    if (LW'(lim) < cut)    cut = LW'(lim);
  end

  assign req_ready   = !active;
  assign sub_valid   = active && (rem != '0) && (!is_rd || hold || any_free);
  assign sub_is_read = is_rd;
  assign sub_addr    = link_a;
  assign sub_local   = loc_a;
  assign sub_len     = cut[SW-1:0];
  assign sub_tag     = !is_rd ? '0 : (hold ? tag_q : free_tag);
  assign issue       = sub_valid && sub_ready;

  assign cpl_ok   = cpl_valid && active && is_rd;
  assign lw_valid = cpl_ok;
  assign lw_addr  = t_addr[cpl_tag];
  assign lw_data  = cpl_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      is_rd   <= 1'b0;
      hold    <= 1'b0;
      done    <= 1'b0;
      link_a  <= '0;
      loc_a   <= '0;
      rem     <= '0;
      rx_left <= '0;
      tag_q   <= '0;
      busy    <= '0;
      for (int i = 0; i < TAGS; i++) begin
        t_addr[i] <= '0;
        t_cnt[i]  <= '0;
      end
    end else begin
      done  <= 1'b0;
      hold  <= sub_valid && !sub_ready;
      tag_q <= sub_tag;
      if (req_valid && !active) begin
        active  <= 1'b1;
        is_rd   <= req_is_read;
        link_a  <= req_link;
        loc_a   <= req_local;
        rem     <= req_len;
        rx_left <= req_len;
      end
      if (issue) begin
        link_a <= link_a + AW'(cut);
        loc_a  <= loc_a + AW'(cut);
        rem    <= rem - cut;
        if (is_rd) begin
          busy[sub_tag]   <= 1'b1;
          t_addr[sub_tag] <= loc_a;
          t_cnt[sub_tag]  <= CW'(cut >> 2);
        end else if (rem == cut) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
      if (cpl_ok) begin
        t_addr[cpl_tag] <= t_addr[cpl_tag] + AW'(4);
        t_cnt[cpl_tag]  <= t_cnt[cpl_tag] - CW'(1);
        if (t_cnt[cpl_tag] == CW'(1)) busy[cpl_tag] <= 1'b0;
        rx_left <= rx_left - LW'(4);
        if (rx_left == LW'(4)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

endmodule

module dma_split_place_chk #(
  parameter int AW   = 32,
  parameter int TAGS = 4,
  localparam int TW  = $clog2(TAGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          sub_valid,
  input logic          sub_ready,
  input logic          sub_is_read,
  input logic [AW-1:0] sub_addr,
  input logic [12:0]   sub_len,
  input logic [TW-1:0] sub_tag,
  input logic [2:0]    cfg_mps,
  input logic [2:0]    cfg_mrrs,
  input logic          lw_valid,
  input logic          done,
  input logic [TAGS-1:0] busy
);
  logic [2:0]  code;
  logic [13:0] cap;
  assign code = sub_is_read ? cfg_mrrs : cfg_mps;
  assign cap  = 14'd128 << ((code > 3'd5) ? 3'd5 : code);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!sub_valid && !lw_valid)); // R1
  AST_NO_4K_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> ({2'b0, sub_addr[11:0]} + {1'b0, sub_len}) <= 14'd4096); // R3
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> ({1'b0, sub_len} <= cap && sub_len != 13'd0 && sub_len[1:0] == 2'b00)); // R4
  AST_TAG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_is_read) |-> !busy[sub_tag]); // R6
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_addr) && $stable(sub_len) && $stable(sub_tag))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R9
endmodule

bind dma_split_place dma_split_place_chk #(.AW(AW), .TAGS(TAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .sub_valid(sub_valid),
  .sub_ready(sub_ready), .sub_is_read(sub_is_read), .sub_addr(sub_addr),
  .sub_len(sub_len), .sub_tag(sub_tag), .cfg_mps(cfg_mps), .cfg_mrrs(cfg_mrrs),
  .lw_valid(lw_valid), .done(done), .busy(busy)
);

// File: tb/tb_dma_split_place.sv
`timescale 1ns/1ps
module tb_dma_split_place;
  localparam int TAGS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_ready, req_is_read = 0;
  logic [31:0] req_link = 0, req_local = 0;
  logic [19:0] req_len = 0;
  logic [2:0]  cfg_mps = 0, cfg_mrrs = 0;
  logic        sub_valid, sub_ready = 0, sub_is_read;
  logic [31:0] sub_addr, sub_local;
  logic [12:0] sub_len;
  logic [1:0]  sub_tag;
  logic        cpl_valid = 0;
  logic [1:0]  cpl_tag = 0;
  logic [31:0] cpl_data = 0;
  logic        lw_valid;
  logic [31:0] lw_addr, lw_data;
  logic        done;

  dma_split_place #(.TAGS(TAGS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_read(req_is_read), .req_link(req_link), .req_local(req_local),
    .req_len(req_len), .cfg_mps(cfg_mps), .cfg_mrrs(cfg_mrrs),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_is_read(sub_is_read),
    .sub_addr(sub_addr), .sub_local(sub_local), .sub_len(sub_len), .sub_tag(sub_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
    .lw_valid(lw_valid), .lw_addr(lw_addr), .lw_data(lw_data), .done(done)
  );

  int compared = 0, mismatched = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  bit          m_active, m_rd, m_hold, m_done;
  logic [31:0] m_link, m_loc, prev_addr;
  int          m_rem, m_rx, m_tagq, prev_len;
  bit          m_busy [TAGS];
  bit          m_used [TAGS];
  logic [31:0] m_base [TAGS];
  int          m_cnt  [TAGS];
  bit          pend, p_rd, seen_done;
  logic [31:0] p_link, p_loc;
  int          p_len, ready_mode, cpl_mode;
  int          wcount [int];

  function automatic int size_cap(input bit rd);
    int e = rd ? int'(cfg_mrrs) : int'(cfg_mps);
    if (e > 5) e = 5;
    return 128 << e;
  endfunction

  function automatic int exp_len();
    int m = m_rem;
    int b = 4096 - int'(m_link[11:0]);
    if (b < m) m = b;
    if (size_cap(m_rd) < m) m = size_cap(m_rd);
    return m;
  endfunction

  function automatic int low_free();
    for (int i = 0; i < TAGS; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int pick_cpl();
    int k;
    if (cpl_mode == 0) begin
      for (int i = TAGS - 1; i >= 0; i--) if (m_busy[i]) return i;
      return -1;
    end
    k = int'($urandom % TAGS);
    for (int j = 0; j < TAGS; j++) if (m_busy[(k + j) % TAGS]) return (k + j) % TAGS;
    return -1;
  endfunction

  task automatic step();
    bit ev, nd, act0;
    int et, el, t;
    @(negedge clk);
    req_valid   = pend && !m_active;
    req_is_read = p_rd;
    req_link    = p_link;
    req_local   = p_loc;
    req_len     = 20'(p_len);
    sub_ready   = (ready_mode != 0) ? ($urandom % 3 != 0) : 1'b1;
    cpl_valid   = 1'b0;
    cpl_tag     = '0;
    cpl_data    = $urandom;
    if (m_active && m_rd && ($urandom % 4 != 0)) begin
      t = pick_cpl();
      if (t >= 0) begin
        cpl_valid = 1'b1;
        cpl_tag   = 2'(t);
      end
    end
    #1;
    ev = m_active && m_rem > 0 && (!m_rd || m_hold || low_free() >= 0);
    et = m_hold ? m_tagq : low_free();
    el = exp_len();
    chk(req_ready == !m_active, "R9", "req_ready", req_ready, !m_active);
    chk(done == m_done, "R9", "done", done, m_done);
    chk(sub_valid == ev, "R6", "sub_valid", sub_valid, ev);
    if (ev && sub_valid) begin
      chk(int'(sub_len) == el, "R2", "sub_len", sub_len, el);
      chk(sub_addr == m_link, "R5", "sub_addr", sub_addr, m_link);
      chk(sub_local == m_loc, "R5", "sub_local", sub_local, m_loc);
      chk(sub_is_read == m_rd, "R5", "sub_is_read", sub_is_read, m_rd);
      chk(int'(sub_len) <= size_cap(m_rd), "R4", "size cap", sub_len, size_cap(m_rd));
      chk(int'(sub_addr[11:0]) + int'(sub_len) <= 4096, "R3", "4K span",
          int'(sub_addr[11:0]) + int'(sub_len), 4096);
      if (m_rd) chk(int'(sub_tag) == et, m_used[et] ? "R8" : "R6", "sub_tag", sub_tag, et);
      if (m_hold) chk(sub_addr == prev_addr && int'(sub_len) == prev_len, "R10", "held offer",
                      sub_addr, prev_addr);
    end
    chk(lw_valid == cpl_valid, "R7", "lw_valid", lw_valid, cpl_valid);
    if (cpl_valid) begin
      chk(lw_addr == m_base[cpl_tag], "R7", "lw_addr", lw_addr, m_base[cpl_tag]);
      chk(lw_data == cpl_data, "R7", "lw_data", lw_data, cpl_data);
      if (wcount.exists(int'(lw_addr))) wcount[int'(lw_addr)]++;
      else wcount[int'(lw_addr)] = 1;
    end
    if (done) seen_done = 1'b1;

    nd = 1'b0;
    act0 = m_active;
    prev_addr = m_link;
    prev_len = el;
    m_hold = ev && !sub_ready;
    m_tagq = et;
    if (req_valid && !act0) begin
      m_active = 1'b1; m_rd = p_rd; m_link = p_link; m_loc = p_loc;
      m_rem = p_len; m_rx = p_len; pend = 1'b0;
    end
    if (ev && sub_ready) begin
      if (m_rd) begin
        m_busy[et] = 1'b1; m_used[et] = 1'b1; m_base[et] = m_loc; m_cnt[et] = el / 4;
      end else if (m_rem == el) begin
        nd = 1'b1; m_active = 1'b0;
      end
      m_link += 32'(el); m_loc += 32'(el); m_rem -= el;
    end
    if (cpl_valid) begin
      t = int'(cpl_tag);
      m_base[t] += 32'd4;
      m_cnt[t]--;
      if (m_cnt[t] == 0) m_busy[t] = 1'b0;
      m_rx -= 4;
      if (m_rx == 0) begin nd = 1'b1; m_active = 1'b0; end
    end
    m_done = nd;
  endtask

  task automatic run(input bit rd, input logic [31:0] link, input logic [31:0] loc,
                     input int len, input int rmode, input int cmode);
    int bad = 0;
    p_rd = rd; p_link = link; p_loc = loc; p_len = len;
    ready_mode = rmode; cpl_mode = cmode;
    pend = 1'b1; seen_done = 1'b0;
    wcount.delete();
    for (int c = 0; c < 60000 && !seen_done; c++) step();
    if (!seen_done) chk(1'b0, "R9", "transfer watchdog", 0, 1);
    if (rd) begin
      for (int a = 0; a < len; a += 4) begin
        int k = int'(loc) + a;
        if (!wcount.exists(k) || wcount[k] != 1) bad++;
      end
      chk(bad == 0 && wcount.size() == len / 4, "R7", "placement coverage", bad, 0);
    end
    ready_mode = 0;
    step();
    step();
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL R9 global watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_active = 0; m_rd = 0; m_hold = 0; m_done = 0; m_rem = 0; m_rx = 0; m_tagq = 0;
    m_link = 0; m_loc = 0; pend = 0; p_rd = 0; p_link = 0; p_loc = 0; p_len = 4;
    ready_mode = 0; cpl_mode = 0;
    for (int i = 0; i < TAGS; i++) begin
      m_busy[i] = 0; m_used[i] = 0; m_base[i] = 0; m_cnt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    chk(sub_valid == 1'b0, "R1", "sub_valid in reset", sub_valid, 0);
    chk(lw_valid == 1'b0, "R1", "lw_valid in reset", lw_valid, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    step();
    step();

    cfg_mps = 3'd0; cfg_mrrs = 3'd5;
    run(1'b0, 32'h0000_0F00, 32'h2000_0000, 500, 0, 0);
    cfg_mps = 3'd5;
    run(1'b0, 32'h0000_1FF4, 32'h0000_0010, 64, 1, 0);
    cfg_mrrs = 3'd2;
    run(1'b1, 32'h0001_0200, 32'h4000_0100, 32'h3000, 1, 0);
    cfg_mrrs = 3'd7; cfg_mps = 3'd0;
    run(1'b1, 32'h0002_0FFC, 32'h8000_0000, 32'h8000, 0, 1);
    cfg_mrrs = 3'd0;
    run(1'b1, 32'h0003_0FFC, 32'h0000_4000, 4, 1, 1);
    cfg_mps = 3'd3;
    run(1'b0, 32'h0004_0000, 32'h0000_8000, 4, 1, 0);
    cfg_mps = 3'd7;
    run(1'b0, 32'h3000_0800, 32'h0001_0000, 32'h2400, 1, 0);
    cfg_mrrs = 3'd1;
    run(1'b1, 32'h0005_0F80, 32'h0002_0000, 32'h0A00, 1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule